// File: doc/BRIEF.md
# Coprocessor handshake sequencer

This block sits between a processor core and an external coprocessor and runs the exchange for one coprocessor instruction at a time. The core hands it an instruction kind, a base address and a source word with a one-cycle `start` pulse. The sequencer then presents phase codes on `cp_phase` and samples the coprocessor's 3-bit answer on `cp_resp` in the same cycle. While the coprocessor answers busy, the sequencer alternates an idle cycle with a re-poll. It gives up on the instruction if an interrupt is pending during one of those idle cycles.

For the two memory kinds the sequencer produces word addresses, starting at the base address and stepping by four for as long as the coprocessor answers with the increment code. It forwards memory read data to the coprocessor, or coprocessor data to memory. Each instruction ends with exactly one single-cycle outcome pulse: completion, undefined-instruction trap, interrupt abandonment, internal address abort or data abort.

States: `S_IDLE`, `S_FIRST`, `S_WAIT`, `S_POLL`, `S_INTR`, `S_UNDEF`, `S_SEND`, `S_RECV`, `S_GAP`, `S_XFER`, `S_LDATA`, `S_SDATA`, `S_DONE`, `S_IABT`, `S_DABT`. Transitions:
- `S_IDLE` goes to `S_FIRST` on start, or to `S_IABT` for a bad memory address.
- `S_FIRST` and `S_POLL` go to `S_WAIT` on busy, to `S_UNDEF` on refusal, and otherwise dispatch by kind to `S_SEND`, `S_RECV`, `S_XFER`, `S_SDATA` or `S_DONE`.
- `S_WAIT` goes to `S_INTR` when an interrupt is pending, else to `S_POLL`.
- `S_RECV` goes to `S_GAP`, then to `S_DONE`.
- `S_XFER` goes to `S_LDATA`.
- `S_LDATA` and `S_SDATA` stay put on increment, else go to `S_DONE` or `S_DABT`.
- `S_SEND`, `S_INTR`, `S_UNDEF`, `S_DONE`, `S_IABT` and `S_DABT` go back to `S_IDLE` (`S_SEND` through `S_DONE`).

Top module: `cop_seq`

## Requirements
- R1: After reset the block is idle: `cp_phase` is 0, no outcome pulse is high, `mem_req` is low and `result` is 0. A `start` seen in the idle state gives phase FIRST (code 1) in the next cycle. A `start` while an instruction is in progress is ignored.
- R2: A busy answer (code 1) to FIRST or to a poll gives one cycle with phase 0, then a poll with phase BUSY (code 2). This repeats for as long as the answer is busy.
- R3: `irq_pending` high during a busy-wait idle cycle gives one cycle of phase INTR (code 3) with `abandon` high, then idle. `irq_pending` in any other cycle has no effect.
- R4: A refusal (code 2) to FIRST or to a poll gives a one-cycle `undef_trap` pulse with no data phase.
- R5: When a from-coprocessor transfer is refused, `result` becomes 0xF0000000, with the four condition-code bits 31:28 set.
- R6: A load or store whose base address has any bit at or above bit 26 set gives a one-cycle `abort_addr` pulse with no phase. A store whose address is below 32 does the same. A load below 32 is legal.
- R7: To-coprocessor (kind 0): one DATA phase (code 5) with `cp_wdata` equal to the source word latched at start, then `done`.
- R8: From-coprocessor (kind 1): one DATA phase that captures `cp_rdata`, one cycle with phase 0, then `done`. `result` holds the captured word until the next capture or refusal.
- R9: Internal operation (kind 2, and kinds 5 to 7) pulses `done` in the cycle after the first non-busy, non-refusal answer.
- R10: Load (kind 3): one TRANSFER phase (code 4), then DATA phases. Each DATA phase reads memory (`mem_req` high, `mem_we` low) and passes `mem_rdata` to `cp_wdata`. An increment answer (code 3) continues at address +4; any other answer ends the burst.
- R11: Store (kind 4): DATA phases with no TRANSFER phase. Each writes `cp_rdata` to memory (`mem_we` high) at the current address, stepping by 4 on each increment answer.
- R12: `mem_abort` high in any beat of a burst replaces `done` with a one-cycle `abort_data` pulse after the burst.
- R13: At most one of `done`, `undef_trap`, `abandon`, `abort_addr` and `abort_data` is high in any cycle. Answer codes: 0 ready, 1 busy, 2 refuse, 3 increment, 4 finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| kind | input | 3 | Instruction kind |
| base_addr | input | 32 | First word address for load/store |
| src_word | input | 32 | Word sent to the coprocessor for kind 0 |
| cp_phase | output | 3 | Phase code presented to the coprocessor |
| cp_resp | input | 3 | Coprocessor answer, sampled in the same cycle |
| cp_wdata | output | 32 | Data to the coprocessor |
| cp_rdata | input | 32 | Data from the coprocessor |
| irq_pending | input | 1 | Interrupt pending |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, same cycle |
| mem_abort | input | 1 | Memory abort for the current beat |
| result | output | 32 | Word returned by a from-coprocessor transfer |
| done | output | 1 | Instruction completed |
| undef_trap | output | 1 | Undefined-instruction trap |
| abandon | output | 1 | Instruction abandoned for an interrupt |
| abort_addr | output | 1 | Internal address abort |
| abort_data | output | 1 | Data abort after a burst |

## Verification
The bench goes after the following corner cases, with the failure each one exposes:
- An interrupt that arrives on the second of several busy waits: a design that sampled it in the wrong cycle would poll once too often or abandon too early.
- An interrupt held high through data beats: a design that did not limit the check to the idle cycle would abandon a burst.
- A refused from-coprocessor transfer: without the forced condition-code word, `result` would keep the stale value.
- A store into the vector region next to a load at the same address: a design that applied the region check to loads would wrongly abort the load.
- Bursts of one and of four beats, with an abort on the first or a middle beat: an off-by-one in address stepping, a lost sticky abort, or a stray TRANSFER phase on stores shows up as an address or outcome mismatch.

// File: rtl/cop_seq_pkg.sv
package cop_seq_pkg;

    typedef enum logic [2:0] {
        K_TO    = 3'd0,
        K_FROM  = 3'd1,
        K_OPER  = 3'd2,
        K_LOAD  = 3'd3,
        K_STORE = 3'd4
    } kind_e;

    typedef enum logic [2:0] {
        PH_NONE  = 3'd0,
        PH_FIRST = 3'd1,
        PH_BUSY  = 3'd2,
        PH_INTR  = 3'd3,
        PH_XFER  = 3'd4,
        PH_DATA  = 3'd5
    } phase_e;

    typedef enum logic [2:0] {
        RS_READY = 3'd0,
        RS_BUSY  = 3'd1,
        RS_CANT  = 3'd2,
        RS_INC   = 3'd3,
        RS_DONE  = 3'd4
    } resp_e;

    typedef enum logic [3:0] {
        S_IDLE, S_FIRST, S_WAIT, S_POLL, S_INTR, S_UNDEF,
        S_SEND, S_RECV, S_GAP, S_XFER, S_LDATA, S_SDATA,
        S_DONE, S_IABT, S_DABT
    } state_e;

endpackage

// File: rtl/cop_seq_addr.sv
module cop_seq_addr
    import cop_seq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LEGAL_BITS = 26,
    parameter int VEC_END    = 32,
    parameter int STEP       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_addr,
    input  logic [2:0]    kind_in,
    input  logic          accept,
    input  logic          step,
    output logic [AW-1:0] addr_q,
    output logic          addr_ok
);

    logic high_bad;
    logic vec_bad;

    generate
        if (LEGAL_BITS < AW) begin : g_high_check
            assign high_bad = |base_addr[AW-1:LEGAL_BITS];
        end else begin : g_no_high_check
            assign high_bad = 1'b0;
        end
    endgenerate

    assign vec_bad = (kind_in == K_STORE) && (base_addr < AW'(VEC_END));
    assign addr_ok = !(high_bad || vec_bad);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      addr_q <= '0;
        else if (accept) addr_q <= base_addr;
        else if (step)   addr_q <= addr_q + AW'(STEP);
    end

    // R10 / R11: each increment answer moves the address by one word
    a_r10_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> addr_q == $past(addr_q) + AW'(STEP));

endmodule

// File: rtl/cop_seq_data.sv
module cop_seq_data #(
    parameter int DW      = 32,
    parameter int CC_BITS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [DW-1:0] src_word,
    input  logic          cap,
    input  logic          force_cc,
    input  logic          sel_mem,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] cp_rdata,
    output logic [DW-1:0] cp_wdata,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] result
);

    localparam logic [DW-1:0] CC_WORD = {{CC_BITS{1'b1}}, {(DW-CC_BITS){1'b0}}};

    logic [DW-1:0] src_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            result <= '0;
        end else begin
            if (accept)        src_q  <= src_word;
            if (cap)           result <= cp_rdata;
            else if (force_cc) result <= CC_WORD;
        end
    end

    assign cp_wdata  = sel_mem ? mem_rdata : src_q;
    assign mem_wdata = cp_rdata;

    // R5: a refused read-back leaves the flag-preserving word
    a_r5_cc_forced: assert property (@(posedge clk) disable iff (!rst_n)
        force_cc |=> result == CC_WORD);

    // R8: the captured coprocessor word appears on result
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> result == $past(cp_rdata));

endmodule

// File: rtl/cop_seq_fsm.sv
module cop_seq_fsm
    import cop_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] kind_in,
    input  logic       addr_ok,
    input  logic [2:0] cp_resp,
    input  logic       irq_pending,
    input  logic       mem_abort,
    output logic [2:0] cp_phase,
    output logic       mem_req,
    output logic       mem_we,
    output logic       accept,
    output logic       step,
    output logic       cap,
    output logic       force_cc,
    output logic       sel_mem,
    output logic       done,
    output logic       undef_trap,
    output logic       abandon,
    output logic       abort_addr,
    output logic       abort_data
);

    state_e     state, nxt;
    logic [2:0] kind_q;
    logic       abt_q;
    logic       is_mem_in;
    logic       in_burst;
    resp_e      rsp;
    state_e     go_state;

    assign rsp       = resp_e'(cp_resp);
    assign is_mem_in = (kind_in == K_LOAD) || (kind_in == K_STORE);
    assign in_burst  = (state == S_LDATA) || (state == S_SDATA);
    assign accept    = (state == S_IDLE) && start;

    always_comb begin
        unique case (kind_q)
            K_TO:    go_state = S_SEND;
            K_FROM:  go_state = S_RECV;
            K_LOAD:  go_state = S_XFER;
            K_STORE: go_state = S_SDATA;
            default: go_state = S_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            kind_q <= '0;
            abt_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) begin
                kind_q <= kind_in;
                abt_q  <= 1'b0;
            end else if (in_burst && mem_abort) begin
                abt_q  <= 1'b1;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:
                if (start) nxt = (is_mem_in && !addr_ok) ? S_IABT : S_FIRST;
            S_FIRST, S_POLL:
                if (rsp == RS_BUSY)      nxt = S_WAIT;
                else if (rsp == RS_CANT) nxt = S_UNDEF;
                else                     nxt = go_state;
            S_WAIT:  nxt = irq_pending ? S_INTR : S_POLL;
            S_SEND:  nxt = S_DONE;
            S_RECV:  nxt = S_GAP;
            S_GAP:   nxt = S_DONE;
            S_XFER:  nxt = S_LDATA;
            S_LDATA, S_SDATA:
                if (rsp != RS_INC) nxt = (abt_q || mem_abort) ? S_DABT : S_DONE;
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        cp_phase   = PH_NONE;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        cap        = 1'b0;
        force_cc   = 1'b0;
        sel_mem    = 1'b0;
        done       = 1'b0;
        undef_trap = 1'b0;
        abandon    = 1'b0;
        abort_addr = 1'b0;
        abort_data = 1'b0;
        unique case (state)
            S_FIRST: cp_phase = PH_FIRST;
            S_POLL:  cp_phase = PH_BUSY;
            S_INTR: begin
                cp_phase = PH_INTR;
                abandon  = 1'b1;
            end
            S_UNDEF: begin
                undef_trap = 1'b1;
                force_cc   = (kind_q == K_FROM);
            end
            S_SEND:  cp_phase = PH_DATA;
            S_RECV: begin
                cp_phase = PH_DATA;
                cap      = 1'b1;
            end
            S_XFER:  cp_phase = PH_XFER;
            S_LDATA: begin
                cp_phase = PH_DATA;
                mem_req  = 1'b1;
                sel_mem  = 1'b1;
            end
            S_SDATA: begin
                cp_phase = PH_DATA;
                mem_req  = 1'b1;
                mem_we   = 1'b1;
            end
            S_DONE:  done       = 1'b1;
            S_IABT:  abort_addr = 1'b1;
            S_DABT:  abort_data = 1'b1;
            default: ;
        endcase
    end

    assign step = in_burst && (rsp == RS_INC);

    // R1: an accepted legal start is followed by the FIRST phase
    a_r1_first_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && (!is_mem_in || addr_ok)) |=> cp_phase == PH_FIRST);

    // R2: every poll is preceded by a cycle with no phase
    a_r2_poll_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_phase == PH_BUSY) |-> $past(cp_phase) == PH_NONE);

    // R3: the interrupt phase only follows a pending interrupt
    a_r3_intr_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_phase == PH_INTR) |-> $past(irq_pending));

    // R6: an address abort comes straight from a start
    a_r6_iabt_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        abort_addr |-> $past(start));

    // R12: a data abort only closes a memory burst
    a_r12_dabt_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
        abort_data |-> $past(mem_req));

    // R13: outcomes are mutually exclusive
    a_r13_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, undef_trap, abandon, abort_addr, abort_data}));

endmodule

// File: rtl/cop_seq.sv
module cop_seq
    import cop_seq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int LEGAL_BITS = 26,
    parameter int VEC_END    = 32,
    parameter int CC_BITS    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    kind,
    input  logic [AW-1:0] base_addr,
    input  logic [DW-1:0] src_word,
    output logic [2:0]    cp_phase,
    input  logic [2:0]    cp_resp,
    output logic [DW-1:0] cp_wdata,
    input  logic [DW-1:0] cp_rdata,
    input  logic          irq_pending,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_abort,
    output logic [DW-1:0] result,
    output logic          done,
    output logic          undef_trap,
    output logic          abandon,
    output logic          abort_addr,
    output logic          abort_data
);

    localparam int STEP = DW / 8;

    logic accept, step, cap, force_cc, sel_mem, addr_ok;

    cop_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .kind_in     (kind),
        .addr_ok     (addr_ok),
        .cp_resp     (cp_resp),
        .irq_pending (irq_pending),
        .mem_abort   (mem_abort),
        .cp_phase    (cp_phase),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .accept      (accept),
        .step        (step),
        .cap         (cap),
        .force_cc    (force_cc),
        .sel_mem     (sel_mem),
        .done        (done),
        .undef_trap  (undef_trap),
        .abandon     (abandon),
        .abort_addr  (abort_addr),
        .abort_data  (abort_data)
    );

    cop_seq_addr #(
        .AW         (AW),
        .LEGAL_BITS (LEGAL_BITS),
        .VEC_END    (VEC_END),
        .STEP       (STEP)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_addr (base_addr),
        .kind_in   (kind),
        .accept    (accept),
        .step      (step),
        .addr_q    (mem_addr),
        .addr_ok   (addr_ok)
    );

    cop_seq_data #(
        .DW      (DW),
        .CC_BITS (CC_BITS)
    ) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .src_word  (src_word),
        .cap       (cap),
        .force_cc  (force_cc),
        .sel_mem   (sel_mem),
        .mem_rdata (mem_rdata),
        .cp_rdata  (cp_rdata),
        .cp_wdata  (cp_wdata),
        .mem_wdata (mem_wdata),
        .result    (result)
    );

endmodule

// File: tb/cop_seq_bench.sv
`timescale 1ns/1ps
module cop_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  kind = 3'd0;
    logic [31:0] base_addr = '0;
    logic [31:0] src_word = '0;
    logic [2:0]  cp_phase;
    logic [2:0]  cp_resp = 3'd0;
    logic [31:0] cp_wdata;
    logic [31:0] cp_rdata = '0;
    logic        irq_pending = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_abort = 1'b0;
    logic [31:0] result;
    logic        done, undef_trap, abandon, abort_addr, abort_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] last_result = '0;

    always #10 clk = ~clk;

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'hC3A5_0F1E;
    endfunction

    assign mem_rdata = memf(mem_addr);

    cop_seq u_cop_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .kind(kind),
        .base_addr(base_addr), .src_word(src_word), .cp_phase(cp_phase),
        .cp_resp(cp_resp), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
        .irq_pending(irq_pending), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_abort(mem_abort), .result(result), .done(done),
        .undef_trap(undef_trap), .abandon(abandon), .abort_addr(abort_addr),
        .abort_data(abort_data)
    );

    // one expected cycle: stimulus to apply plus outputs to expect
    typedef struct packed {
        logic [3:0]  tag;
        logic        st;
        logic        irq;
        logic        mabt;
        logic [2:0]  resp;
        logic [31:0] crd;
        logic [2:0]  ph;
        logic [4:0]  outc;   // done, trap, abandon, addr abort, data abort
        logic        req;
        logic        we;
        logic [31:0] addr;
        logic        chk_wd;
        logic [31:0] wd;
        logic        chk_res;
        logic [31:0] res;
    } rec_t;

    rec_t q[$];

    task automatic chk(input int tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic rec_t blank(input int tag, input bit noise);
        rec_t r;
        r = '0;
        r.tag = 4'(tag);
        r.st  = noise;
        r.irq = noise;
        return r;
    endfunction

    task automatic play();
        while (q.size() > 0) begin
            rec_t r;
            r = q.pop_front();
            @(negedge clk);
            start       = r.st;
            cp_resp     = r.resp;
            irq_pending = r.irq;
            mem_abort   = r.mabt;
            cp_rdata    = r.crd;
            #1;
            chk(r.tag, "phase", 32'(cp_phase), 32'(r.ph));
            chk(r.tag, "outcome", 32'({done, undef_trap, abandon, abort_addr, abort_data}), 32'(r.outc));
            chk(r.tag, "mem_req", 32'(mem_req), 32'(r.req));
            if (r.req) begin
                chk(r.tag, "mem_we", 32'(mem_we), 32'(r.we));
                chk(r.tag, "mem_addr", mem_addr, r.addr);
                if (r.we) chk(r.tag, "mem_wdata", mem_wdata, r.crd);
            end
            if (r.chk_wd)  chk(r.tag, "cp_wdata", cp_wdata, r.wd);
            if (r.chk_res) chk(r.tag, "result", result, r.res);
        end
    endtask

    // build the expected trace of one instruction from the requirements
    task automatic run_op(input int tag, input logic [2:0] k, input logic [31:0] a,
                          input logic [31:0] src, input int nbusy, input logic [2:0] fin,
                          input int irq_at, input int nburst, input int abt_at,
                          input bit noise, input logic [31:0] crd_base);
        rec_t r;
        bit   is_mem, legal, gone, dabt;
        kind = k; base_addr = a; src_word = src;
        is_mem = (k == 3'd3) || (k == 3'd4);
        legal  = !(is_mem && ((a[31:26] != 0) || (k == 3'd4 && a < 32)));
        r = blank(tag, noise); r.st = 1'b1; q.push_back(r);
        if (!legal) begin
            r = blank(6, noise); r.outc = 5'b00010; q.push_back(r);   // R6
        end else begin
            r = blank(1, noise); r.ph = 3'd1;
            r.resp = (nbusy > 0) ? 3'd1 : fin; q.push_back(r);
            gone = 0;
            for (int i = 1; i <= nbusy; i++) begin
                r = blank(2, noise); r.irq = (i == irq_at); q.push_back(r);
                if (i == irq_at) begin
                    r = blank(3, noise); r.ph = 3'd3; r.outc = 5'b00100; q.push_back(r);
                    gone = 1;
                    break;
                end
                r = blank(2, noise); r.ph = 3'd2;
                r.resp = (i < nbusy) ? 3'd1 : fin; q.push_back(r);
            end
            if (!gone && fin == 3'd2) begin
                r = blank(4, noise); r.outc = 5'b01000; q.push_back(r);
                if (k == 3'd1) last_result = 32'hF000_0000;     // R5
            end else if (!gone) begin
                unique case (k)
                    3'd0: begin
                        r = blank(7, noise); r.ph = 3'd5; r.chk_wd = 1; r.wd = src; q.push_back(r);
                        r = blank(7, noise); r.outc = 5'b10000; q.push_back(r);
                    end
                    3'd1: begin
                        r = blank(8, noise); r.ph = 3'd5; r.crd = crd_base; q.push_back(r);
                        r = blank(8, noise); q.push_back(r);
                        r = blank(8, noise); r.outc = 5'b10000; r.chk_res = 1; r.res = crd_base;
                        q.push_back(r);
                        last_result = crd_base;
                    end
                    3'd3, 3'd4: begin
                        if (k == 3'd3) begin
                            r = blank(10, noise); r.ph = 3'd4; q.push_back(r);
                        end
                        dabt = 0;
                        for (int b = 0; b <= nburst; b++) begin
                            r = blank((k == 3'd3) ? 10 : 11, noise);
                            r.ph = 3'd5; r.req = 1; r.we = (k == 3'd4);
                            r.addr = a + 32'(4 * b);
                            r.resp = (b < nburst) ? 3'd3 : 3'd4;
                            r.mabt = (b == abt_at);
                            if (b == abt_at) dabt = 1;
                            if (k == 3'd3) begin r.chk_wd = 1; r.wd = memf(r.addr); end
                            else r.crd = crd_base + 32'(b);
                            q.push_back(r);
                        end
                        r = blank(12, noise); r.outc = dabt ? 5'b00001 : 5'b10000; q.push_back(r);
                    end
                    default: begin
                        r = blank(9, noise); r.outc = 5'b10000; q.push_back(r);
                    end
                endcase
            end
        end
        r = blank(13, 1'b0); r.chk_res = 1; r.res = last_result; q.push_back(r);
        play();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(1, "reset phase", 32'(cp_phase), 32'd0);
        chk(1, "reset outcome", 32'({done, undef_trap, abandon, abort_addr, abort_data}), 32'd0);
        chk(1, "reset mem_req", 32'(mem_req), 32'd0);
        chk(1, "reset result", result, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        // R9: internal op, immediate ready; kind 6 behaves the same
        run_op(9, 3'd2, 32'h0, 32'h0, 0, 3'd0, 0, 0, -1, 0, 32'h0);
        run_op(9, 3'd6, 32'h0, 32'h0, 1, 3'd0, 0, 0, -1, 0, 32'h0);
        // R7 with R2: two busy rounds before the data phase
        run_op(7, 3'd0, 32'h0, 32'hDEAD_BEEF, 2, 3'd0, 0, 0, -1, 0, 32'h0);
        // R8: read-back after one busy round
        run_op(8, 3'd1, 32'h0, 32'h0, 1, 3'd0, 0, 0, -1, 0, 32'h1234_5678);
        // R4 and R5: refused read-back forces the condition-code word
        run_op(4, 3'd1, 32'h0, 32'h0, 1, 3'd2, 0, 0, -1, 0, 32'h0);
        run_op(4, 3'd0, 32'h0, 32'h5, 0, 3'd2, 0, 0, -1, 0, 32'h0);
        // R3: interrupt on the second busy wait, irq high elsewhere, start noise (R1)
        run_op(3, 3'd2, 32'h0, 32'h0, 3, 3'd0, 2, 0, -1, 1, 32'h0);
        // R10: load burst of four words
        run_op(10, 3'd3, 32'h100, 32'h0, 0, 3'd0, 0, 3, -1, 0, 32'h0);
        // R11: store burst of three words, after one busy round
        run_op(11, 3'd4, 32'h200, 32'h0, 1, 3'd0, 0, 2, -1, 0, 32'hA000_0000);
        // R6: store into the vector region, load above the legal range
        run_op(6, 3'd4, 32'h10, 32'h0, 0, 3'd0, 0, 0, -1, 0, 32'h0);
        run_op(6, 3'd3, 32'h0400_0000, 32'h0, 0, 3'd0, 0, 0, -1, 0, 32'h0);
        // R6: a load in the vector region is legal
        run_op(6, 3'd3, 32'h10, 32'h0, 0, 3'd0, 0, 0, -1, 0, 32'h0);
        // R12: abort on a middle beat and on a single-beat load
        run_op(12, 3'd4, 32'h300, 32'h0, 0, 3'd0, 0, 3, 1, 0, 32'hB000_0000);
        run_op(12, 3'd3, 32'h400, 32'h0, 0, 3'd0, 0, 0, 0, 1, 32'h0);
        // R1: start held through a whole read-back is not re-accepted
        run_op(1, 3'd1, 32'h0, 32'h0, 1, 3'd0, 0, 0, -1, 1, 32'h0BAD_F00D);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R13 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule